// File: doc/BRIEF.md
# Shared Packet Buffer with Register Handshake

This block holds one packet at a time in a 64-bit wide buffer that a processor reaches over a 32-bit memory-mapped bus. Inbound packets arrive on a 64-bit valid/ready/last stream. A receive machine writes them into the buffer and then keeps the packet until software hands the buffer back. Outbound packets are written by software through the same window and then submitted. A transmit machine then streams them out with valid/ready/last.

Ownership of each side passes through a four-phase level handshake on a single control word. Software raises a request bit and waits for the matching status bit to change. It then lowers the request before another exchange can begin. Bus word address 2k maps to the low 32 bits of buffer word k, and 2k+1 maps to the high 32 bits. One address above the window (`CSR_WADDR`) is the register: a write sets the control word and a read returns the status word. Any other address reads as zero.

Top module: `pkt_buf_mmio`

## Requirements
- R1: Status bit 31 is 1 from the cycle after the inbound word carrying `rx_last_i` is accepted until a release is seen; the receive buffer is then held.
- R2: Status bits 12:0 give 8 times the number of inbound words stored. At most `BUF_WORDS` words are stored: words past that are accepted but dropped, and the count stops at `BUF_WORDS*8`.
- R3: Control bit 31 is the release request. If it is 1 while a packet is held, status bit 31 reads 0 from the next cycle. While it is 1, `rx_ready_o` stays 0. When it returns to 0, the count clears and the next packet can fill.
- R4: While a packet is held and no release is requested, `rx_ready_o` is 0, inbound words are ignored, and both the count and the buffer contents stay unchanged.
- R5: Status bit 30 is 1 only while the transmit side is idle. A 1 on control bit 30 in that state latches control bits 12:0 as the byte length, drops status bit 30 the next cycle and starts sending.
- R6: A submitted length L sends ceil(L/8) buffer words, capped at `BUF_WORDS`, from word 0 upward. `tx_last_o` is set on the final word. While `tx_ready_i` is 0, valid, data and last hold.
- R7: After sending, status bit 30 stays 0 until control bit 30 has been seen at 0.
- R8: A submitted length of 0 sends no word, and status bit 30 still waits for control bit 30 to clear.
- R9: A bus read returns its data on `bus_rdata_o` in the cycle after the request, and `bus_rdata_o` keeps that value until the next read. A bus write to the window updates only the addressed 32-bit half.
- R10: After reset the control word is 0, status reads 32'h4000_0000, `rx_ready_o` is 1 and `tx_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | Bus write (1) or read (0) |
| bus_addr_i | input | AW | Bus 32-bit word address |
| bus_wdata_i | input | 32 | Bus write data |
| bus_rdata_o | output | 32 | Bus read data, registered |
| rx_data_i | input | 64 | Inbound stream data |
| rx_valid_i | input | 1 | Inbound stream valid |
| rx_last_i | input | 1 | Inbound final word |
| rx_ready_o | output | 1 | Inbound stream ready |
| tx_data_o | output | 64 | Outbound stream data |
| tx_valid_o | output | 1 | Outbound stream valid |
| tx_last_o | output | 1 | Outbound final word |
| tx_ready_i | input | 1 | Outbound stream ready |

## Verification
A control write takes effect at the clock edge that ends the write cycle, and the state machines act on it at the following edge. Status therefore changes two edges after the write starts, and a read captures status as it stands at the edge that ends the read cycle. The inbound hold (R1) appears one edge after the accepted last word. Transmit valid rises one edge after the submit is seen, and every outbound word moves on the edge where ready is high. The bench keeps a behavioural model that updates on these same edges from the applied inputs only. It compares ready, valid, last, data and read data at each falling edge. Directed reads are placed one or two idle cycles after a control write, so that the expected status is unambiguous.

// File: rtl/pkt_buf_pkg.sv
package pkt_buf_pkg;
  localparam int unsigned CNT_W = 13;
  typedef enum logic [1:0] {RX_FILL, RX_HELD, RX_DRAIN} rx_state_e;
  typedef enum logic [1:0] {TX_IDLE, TX_SEND, TX_WAIT} tx_state_e;
endpackage

// File: rtl/pkt_buf_ram.sv
module pkt_buf_ram #(
  parameter int unsigned WORDS = 64,
  localparam int unsigned IDX_W = $clog2(WORDS)
) (
  input  logic             clk_i,
  input  logic             rx_we_i,
  input  logic [IDX_W-1:0] rx_idx_i,
  input  logic [63:0]      rx_wdata_i,
  input  logic             bus_we_i,
  input  logic [IDX_W-1:0] bus_idx_i,
  input  logic             bus_hi_i,
  input  logic [31:0]      bus_wdata_i,
  output logic [63:0]      bus_rdata_o,
  input  logic [IDX_W-1:0] tx_idx_i,
  output logic [63:0]      tx_rdata_o
);
  logic [63:0] mem_q [WORDS];

  // inbound write is placed last so it wins a same-word collision
  always_ff @(posedge clk_i) begin
    if (bus_we_i) begin
      if (bus_hi_i) mem_q[bus_idx_i][63:32] <= bus_wdata_i;
      else          mem_q[bus_idx_i][31:0]  <= bus_wdata_i;
    end
    if (rx_we_i) mem_q[rx_idx_i] <= rx_wdata_i;
  end

  assign bus_rdata_o = mem_q[bus_idx_i];
  assign tx_rdata_o  = mem_q[tx_idx_i];
endmodule

// File: rtl/pkt_buf_rx.sv
module pkt_buf_rx
  import pkt_buf_pkg::*;
#(
  parameter int unsigned WORDS = 64,
  localparam int unsigned IDX_W = $clog2(WORDS),
  localparam int unsigned CW    = $clog2(WORDS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [63:0]      data_i,
  input  logic             valid_i,
  input  logic             last_i,
  output logic             ready_o,
  input  logic             rel_i,
  output logic             held_o,
  output logic [CNT_W-1:0] bytes_o,
  output logic             we_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [63:0]      wdata_o
);
  rx_state_e     state_q;
  logic [CW-1:0] wcnt_q;
  logic          accept;
  logic          room;

  assign ready_o = (state_q == RX_FILL) && !rel_i;
  assign accept  = valid_i && ready_o;
  assign room    = wcnt_q < CW'(WORDS);
  assign we_o    = accept && room;
  assign idx_o   = wcnt_q[IDX_W-1:0];
  assign wdata_o = data_i;
  assign held_o  = (state_q == RX_HELD);
  assign bytes_o = CNT_W'({wcnt_q, 3'b000});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_FILL;
      wcnt_q  <= '0;
    end else begin
      unique case (state_q)
        RX_FILL: if (accept) begin
          if (room) wcnt_q <= wcnt_q + CW'(1);
          if (last_i) state_q <= RX_HELD;
        end
        RX_HELD: if (rel_i) state_q <= RX_DRAIN;
        RX_DRAIN: if (!rel_i) begin
          state_q <= RX_FILL;
          wcnt_q  <= '0;
        end
        default: state_q <= RX_FILL;
      endcase
    end
  end

  p_held_after_last_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o && last_i) |=> held_o);
  p_no_overflow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bytes_o <= CNT_W'(WORDS * 8));
  p_release_drops_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (held_o && rel_i) |=> !held_o);
  p_no_fill_after_drop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(held_o) && rel_i) |-> !ready_o);
  p_hold_stable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (held_o && !rel_i) |=> (held_o && $stable(bytes_o)));
endmodule

// File: rtl/pkt_buf_tx.sv
module pkt_buf_tx
  import pkt_buf_pkg::*;
#(
  parameter int unsigned WORDS = 64,
  localparam int unsigned IDX_W = $clog2(WORDS),
  localparam int unsigned CW    = $clog2(WORDS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             submit_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             idle_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             valid_o,
  output logic             last_o,
  input  logic             ready_i
);
  tx_state_e        state_q;
  logic [CW-1:0]    nwords_q;
  logic [CW-1:0]    idx_q;
  logic [CNT_W:0]   words_req;
  logic [CW-1:0]    words_cap;

  // ceil(len/8), capped to the buffer size
  assign words_req = ((CNT_W + 1)'(len_i) + (CNT_W + 1)'(7)) >> 3;
  assign words_cap = (words_req > (CNT_W + 1)'(WORDS)) ? CW'(WORDS) : CW'(words_req);

  assign idle_o  = (state_q == TX_IDLE);
  assign valid_o = (state_q == TX_SEND);
  assign last_o  = valid_o && (idx_q == nwords_q - CW'(1));
  assign idx_o   = idx_q[IDX_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= TX_IDLE;
      nwords_q <= '0;
      idx_q    <= '0;
    end else begin
      unique case (state_q)
        TX_IDLE: if (submit_i) begin
          nwords_q <= words_cap;
          idx_q    <= '0;
          state_q  <= (words_cap == '0) ? TX_WAIT : TX_SEND;
        end
        TX_SEND: if (ready_i) begin
          if (last_o) state_q <= TX_WAIT;
          else        idx_q   <= idx_q + CW'(1);
        end
        TX_WAIT: if (!submit_i) state_q <= TX_IDLE;
        default: state_q <= TX_IDLE;
      endcase
    end
  end

  p_submit_starts_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_o && submit_i) |=> !idle_o);
  p_stall_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(idx_o) && $stable(last_o)));
  p_idle_needs_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(idle_o) |-> !$past(submit_i));
endmodule

// File: rtl/pkt_buf_mmio.sv
module pkt_buf_mmio
  import pkt_buf_pkg::*;
#(
  parameter int unsigned BUF_WORDS = 64,
  parameter int unsigned CSR_WADDR = 128,
  localparam int unsigned IDX_W = $clog2(BUF_WORDS),
  localparam int unsigned AW    = $clog2(CSR_WADDR + 1),
  localparam int unsigned WIN   = 2 * BUF_WORDS
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_req_i,
  input  logic          bus_we_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [31:0]   bus_wdata_i,
  output logic [31:0]   bus_rdata_o,
  input  logic [63:0]   rx_data_i,
  input  logic          rx_valid_i,
  input  logic          rx_last_i,
  output logic          rx_ready_o,
  output logic [63:0]   tx_data_o,
  output logic          tx_valid_o,
  output logic          tx_last_o,
  input  logic          tx_ready_i
);
  logic             rel_q, sub_q;
  logic [CNT_W-1:0] len_q;
  logic             win_hit, csr_hit, win_we;
  logic             rx_held, tx_idle, rx_we;
  logic [CNT_W-1:0] rx_bytes;
  logic [IDX_W-1:0] rx_idx, tx_idx;
  logic [63:0]      rx_wdata, ram_bus_rd;
  logic [31:0]      status, rd_mux;

  assign win_hit = bus_addr_i < AW'(WIN);
  assign csr_hit = bus_addr_i == AW'(CSR_WADDR);
  assign win_we  = bus_req_i && bus_we_i && win_hit;
  assign status  = {rx_held, tx_idle, 17'd0, rx_bytes};

  always_comb begin
    rd_mux = '0;
    if (csr_hit)      rd_mux = status;
    else if (win_hit) rd_mux = bus_addr_i[0] ? ram_bus_rd[63:32] : ram_bus_rd[31:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rel_q       <= 1'b0;
      sub_q       <= 1'b0;
      len_q       <= '0;
      bus_rdata_o <= '0;
    end else if (bus_req_i) begin
      if (!bus_we_i) bus_rdata_o <= rd_mux;
      else if (csr_hit) begin
        rel_q <= bus_wdata_i[31];
        sub_q <= bus_wdata_i[30];
        len_q <= bus_wdata_i[CNT_W-1:0];
      end
    end
  end

  pkt_buf_ram #(.WORDS(BUF_WORDS)) u_ram (
    .clk_i       (clk_i),
    .rx_we_i     (rx_we),
    .rx_idx_i    (rx_idx),
    .rx_wdata_i  (rx_wdata),
    .bus_we_i    (win_we),
    .bus_idx_i   (bus_addr_i[IDX_W:1]),
    .bus_hi_i    (bus_addr_i[0]),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (ram_bus_rd),
    .tx_idx_i    (tx_idx),
    .tx_rdata_o  (tx_data_o)
  );

  pkt_buf_rx #(.WORDS(BUF_WORDS)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .data_i  (rx_data_i),
    .valid_i (rx_valid_i),
    .last_i  (rx_last_i),
    .ready_o (rx_ready_o),
    .rel_i   (rel_q),
    .held_o  (rx_held),
    .bytes_o (rx_bytes),
    .we_o    (rx_we),
    .idx_o   (rx_idx),
    .wdata_o (rx_wdata)
  );

  pkt_buf_tx #(.WORDS(BUF_WORDS)) u_tx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .submit_i (sub_q),
    .len_i    (len_q),
    .idle_o   (tx_idle),
    .idx_o    (tx_idx),
    .valid_o  (tx_valid_o),
    .last_o   (tx_last_o),
    .ready_i  (tx_ready_i)
  );

  p_stall_data_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i && !win_we && !rx_we) |=> $stable(tx_data_o));
  p_read_latency_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_req_i && !bus_we_i) |=> $stable(bus_rdata_o));
endmodule

// File: tb/pkt_buf_mmio_tb.sv
module pkt_buf_mmio_tb;
  localparam int BUF  = 64;
  localparam int CSR  = 128;
  localparam int AW   = $clog2(CSR + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_req = 1'b0, bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [63:0]   rx_data = '0;
  logic          rx_valid = 1'b0, rx_last = 1'b0;
  logic          rx_ready;
  logic [63:0]   tx_data;
  logic          tx_valid, tx_last;
  logic          tx_ready = 1'b1;

  int checks = 0, errors = 0;
  bit stall_mode = 1'b0;
  int cyc = 0;

  always #4 clk = ~clk;

  pkt_buf_mmio #(.BUF_WORDS(BUF), .CSR_WADDR(CSR)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_req_i(bus_req), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .rx_data_i(rx_data), .rx_valid_i(rx_valid), .rx_last_i(rx_last), .rx_ready_o(rx_ready),
    .tx_data_o(tx_data), .tx_valid_o(tx_valid), .tx_last_o(tx_last), .tx_ready_i(tx_ready)
  );

  // behavioural reference, advanced on the same edges from applied inputs only
  int m_rx, m_tx, m_wc, m_n, m_idx;
  logic [31:0] m_ctrl, m_rdata, m_oc;
  logic [63:0] m_mem [BUF];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rx = 0; m_tx = 0; m_wc = 0; m_n = 0; m_idx = 0;
      m_ctrl = '0; m_rdata = '0;
    end else begin
      m_oc = m_ctrl;
      if (bus_req && !bus_we) begin
        if (int'(bus_addr) == CSR)
          m_rdata = {m_rx == 1, m_tx == 0, 17'd0, 13'(m_wc * 8)};
        else if (int'(bus_addr) < 2 * BUF)
          m_rdata = bus_addr[0] ? m_mem[int'(bus_addr) / 2][63:32] : m_mem[int'(bus_addr) / 2][31:0];
        else m_rdata = '0;
      end
      if (bus_req && bus_we) begin
        if (int'(bus_addr) == CSR) m_ctrl = bus_wdata;
        else if (int'(bus_addr) < 2 * BUF) begin
          if (bus_addr[0]) m_mem[int'(bus_addr) / 2][63:32] = bus_wdata;
          else             m_mem[int'(bus_addr) / 2][31:0]  = bus_wdata;
        end
      end
      case (m_rx)
        0: if (!m_oc[31] && rx_valid) begin
          if (m_wc < BUF) begin m_mem[m_wc] = rx_data; m_wc++; end
          if (rx_last) m_rx = 1;
        end
        1: if (m_oc[31]) m_rx = 2;
        default: if (!m_oc[31]) begin m_rx = 0; m_wc = 0; end
      endcase
      case (m_tx)
        0: if (m_oc[30]) begin
          m_n = (int'(m_oc[12:0]) + 7) / 8;
          if (m_n > BUF) m_n = BUF;
          m_idx = 0;
          m_tx = (m_n == 0) ? 2 : 1;
        end
        1: if (tx_ready) begin
          if (m_idx == m_n - 1) m_tx = 2; else m_idx++;
        end
        default: if (!m_oc[30]) m_tx = 0;
      endcase
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // every-clock comparison against the model
  always @(negedge clk) begin
    cyc++;
    tx_ready = stall_mode ? cyc[0] : 1'b1;
    if (rst_n) begin
      chk(rx_ready === (m_rx == 0 && !m_ctrl[31]), "R4 rx_ready", 64'(rx_ready), 64'(m_rx == 0 && !m_ctrl[31]));
      chk(tx_valid === (m_tx == 1), "R5 tx_valid", 64'(tx_valid), 64'(m_tx == 1));
      if (m_tx == 1) begin
        chk(tx_last === (m_idx == m_n - 1), "R6 tx_last", 64'(tx_last), 64'(m_idx == m_n - 1));
        chk(tx_data === m_mem[m_idx], "R6 tx_data", tx_data, m_mem[m_idx]);
      end
      chk(bus_rdata === m_rdata, "R9 bus_rdata", 64'(bus_rdata), 64'(m_rdata));
    end
  end

  // observed outbound handshakes
  int sent = 0, last_at = 0;
  always @(posedge clk) if (rst_n && tx_valid && tx_ready) begin
    sent++;
    if (tx_last) last_at = sent;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input int a, input logic [31:0] exp, input string tag);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = AW'(a);
    @(negedge clk);
    bus_req = 1'b0;
    chk(bus_rdata === exp, tag, 64'(bus_rdata), 64'(exp));
  endtask

  function automatic logic [63:0] rx_word(input int i);
    return {32'hB000 + 32'(i), 32'hC000 + 32'(i)};
  endfunction

  task automatic send_rx(input int n);
    for (int i = 0; i < n; i++) begin
      rx_valid = 1'b1; rx_data = rx_word(i); rx_last = (i == n - 1);
      do @(posedge clk); while (!rx_ready);
      @(negedge clk);
    end
    rx_valid = 1'b0; rx_last = 1'b0;
  endtask

  task automatic release_rx;
    wr(CSR, 32'h8000_0000); tick(2);
    wr(CSR, 32'h0); tick(2);
  endtask

  task automatic run_tx(input int len, input int exp_words, input string tag);
    int base;
    base = sent;
    wr(CSR, 32'h4000_0000 | 32'(len));
    tick(1);
    while (m_tx != 2) @(negedge clk);
    tick(3);
    chk(sent - base == exp_words, tag, 64'(sent - base), 64'(exp_words));
    if (exp_words > 0)
      chk(last_at - base == exp_words, {tag, " last"}, 64'(last_at - base), 64'(exp_words));
    rd(CSR, 32'h0, "R7 status30 low until clear");
    wr(CSR, 32'h0); tick(2);
    rd(CSR, 32'h4000_0000, "R7 idle after clear");
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R10 reset state
    chk(rx_ready === 1'b1, "R10 rx_ready after reset", 64'(rx_ready), 64'd1);
    chk(tx_valid === 1'b0, "R10 tx_valid after reset", 64'(tx_valid), 64'd0);
    rd(CSR, 32'h4000_0000, "R10 status after reset");

    // initial release handshake: R3 ready low while requested
    wr(CSR, 32'h8000_0000);
    chk(rx_ready === 1'b0, "R3 ready low during release", 64'(rx_ready), 64'd0);
    tick(1);
    wr(CSR, 32'h0); tick(2);

    // R1 R2 receive a three-word packet
    send_rx(3);
    tick(1);
    rd(CSR, 32'hC000_0018, "R1 held with 24 bytes");
    rd(0, 32'hC000, "R9 word0 low half");
    rd(1, 32'hB000, "R9 word0 high half");
    rd(5, 32'hB002, "R9 word2 high half");

    // R4 inbound traffic while held is ignored
    rx_valid = 1'b1; rx_data = 64'hDEAD_BEEF_0BAD_F00D; rx_last = 1'b1;
    tick(3);
    rx_valid = 1'b0; rx_last = 1'b0;
    rd(CSR, 32'hC000_0018, "R4 count unchanged while held");
    rd(0, 32'hC000, "R4 buffer unchanged while held");

    // R3 release handshake
    wr(CSR, 32'h8000_0000); tick(1);
    rd(CSR, 32'h4000_0018, "R3 held drops on release");
    chk(rx_ready === 1'b0, "R3 ready low until request clears", 64'(rx_ready), 64'd0);
    wr(CSR, 32'h0); tick(1);
    rd(CSR, 32'h4000_0000, "R3 count cleared");
    chk(rx_ready === 1'b1, "R3 fill resumes", 64'(rx_ready), 64'd1);

    // R2 overflow: 70 words into 64
    send_rx(70);
    tick(1);
    rd(CSR, 32'hC000_0200, "R2 count saturates");
    rd(2 * 63, 32'hC000 + 32'd63, "R2 last slot keeps word 63");
    release_rx;

    // transmit: fill 8 words via bus
    for (int k = 0; k < 8; k++) begin
      wr(2 * k, 32'h1100 + 32'(k));
      wr(2 * k + 1, 32'h2200 + 32'(k));
    end
    rd(CSR, 32'h4000_0000, "R5 idle before submit");
    rd(3, 32'h2201, "R9 half write");

    stall_mode = 1'b1;
    run_tx(44, 6, "R6 len44 with stalls sends 6 words");
    stall_mode = 1'b0;
    run_tx(64, 8, "R6 len64 sends 8 words");
    run_tx(0, 0, "R8 zero length sends nothing");
    run_tx(9000, 64, "R6 length capped at buffer");

    tick(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule